// File: doc/BRIEF.md
# Bus-Master DMA Channel Register Front End

This block is the software-facing register set of one bus-master DMA channel for a disk-style drive port. It holds a command byte (run flag and transfer direction), a status byte (active, error, interrupt) and a 32-bit pointer to the descriptor table in host memory. The descriptor walker behind it sees plain control pins: a one-cycle start pulse, a one-cycle stop pulse, the direction, the channel-active level and a fetch pointer. The fetch pointer is loaded from the table base on every run request and stepped by one descriptor size each time the walker reports a fetch.

Clearing the run flag never cuts a transfer short. While the walker reports an in-flight transfer, the stop is held pending. It takes effect in the first cycle in which the walker is idle. The drive interrupt goes straight through to the host. Its rising edge is also recorded in the status byte, so software can tell which channel raised it.

Register access is a single-cycle strobe with a byte offset and an access size. Read data is combinational on the selected register. There is no back-pressure on the register port: every strobe is accepted in the cycle it is presented.

Top module: `bmr_regs`

## Requirements
- R1: A command write (select 0) keeps only data bit 0 (run) and bit 3 (direction). A command read returns those two bits in place, with every other bit zero.
- R2: A command write whose bit 0 equals the stored run bit produces neither a start nor a stop pulse and does not reload the fetch pointer. It still updates the direction bit.
- R3: A command write that changes the run bit from 0 to 1 does three things on the next cycle: it loads the fetch pointer from the table base, sets the active bit, and gives one start pulse. The pulse and the set are skipped if the channel is still active.
- R4: A command write that changes the run bit from 1 to 0 while `wk_busy` is high is held pending. Active stays set until `wk_busy` is low. Only then are active cleared and one stop pulse issued. No stop pulse ever follows a busy cycle.
- R5: A table-base write (select 2) replaces only the byte lanes from `acc_off` up to `acc_off` plus the size. Size is encoded 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes. Lanes past byte 3 are dropped, and base bits 1:0 always read as zero.
- R6: A table-base read returns the pointer shifted right by 8 x `acc_off`, masked to the access size. Command and status reads ignore offset and size. A read with select 3 returns zero.
- R7: `host_irq` follows `drv_irq` in the same cycle. A rising edge of `drv_irq` sets the interrupt status bit; a falling edge leaves status unchanged.
- R8: Reset clears the command, status, table base, fetch pointer and pending stop, and ends any active transfer.
- R9: Status (select 1) has bit 0 = active, bit 1 = error, bit 2 = interrupt, with the other bits zero. Writing 1 to bit 1 or 2 clears it. Writes to bit 0 have no effect.
- R10: `wk_done` or `wk_exhaust` clears the active bit, and `wk_exhaust` also sets the error bit. A hardware set wins over a software clear in the same cycle.
- R11: Each cycle with `wk_advance` high adds 8 to the fetch pointer, unless a start reload happens in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Register access strobe |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_sel | input | 2 | 0 command, 1 status, 2 table base, 3 unused |
| acc_off | input | 2 | Byte offset within the table base |
| acc_size | input | 2 | Access size: 0 = 1 byte, 1 = 2 bytes, 2/3 = 4 bytes |
| acc_wdata | input | 32 | Write data, low-aligned |
| acc_rdata | output | 32 | Read data of the selected register |
| wk_start | output | 1 | One-cycle run request to the walker |
| wk_stop | output | 1 | One-cycle stop notice to the walker |
| wk_fetch_ptr | output | 32 | Address of the next descriptor to fetch |
| wk_dir | output | 1 | Stored direction bit |
| wk_busy | input | 1 | Walker has a transfer in flight |
| wk_advance | input | 1 | Walker fetched one descriptor |
| wk_done | input | 1 | Walker finished the transfer |
| wk_exhaust | input | 1 | Walker ran out of descriptors |
| chan_active | output | 1 | Active status bit |
| drv_irq | input | 1 | Drive interrupt level |
| host_irq | output | 1 | Interrupt to the host |

## Verification
The assertions run on every cycle and cover the per-cycle rules:
- command bits are retained and an unchanged run bit produces no pulses;
- the fetch pointer is loaded from the base on a start;
- active is never dropped while a stop waits on a busy walker, and no stop pulse follows a busy cycle;
- base bits 1:0 stay zero after a write;
- interrupt and error bits set on their events.

Only the bench's scenarios can show the byte-lane merge and the shifted readback for each offset and size, the timing of a deferred stop, the write-1-clear behaviour, and the full clear on reset in the middle of a run. There, a behavioural model tracks the walker-facing outputs cycle by cycle.

// File: rtl/bmr_pkg.sv
package bmr_pkg;

  typedef enum logic [1:0] {
    SEL_CMD  = 2'd0,
    SEL_STAT = 2'd1,
    SEL_BASE = 2'd2,
    SEL_NONE = 2'd3
  } bmr_sel_e;

  localparam int CMD_RUN_BIT = 0;
  localparam int CMD_DIR_BIT = 3;

  localparam int ST_ACT_BIT = 0;
  localparam int ST_ERR_BIT = 1;
  localparam int ST_INT_BIT = 2;

endpackage

// File: rtl/bmr_base_reg.sv
module bmr_base_reg #(
  parameter int PTR_W = 32,
  parameter int ALIGN = 2,
  localparam int NB = PTR_W / 8,
  localparam int OFF_W = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic [1:0]       size_i,
  input  logic [PTR_W-1:0] wdata_i,
  output logic [PTR_W-1:0] base_o,
  output logic [PTR_W-1:0] rdata_o
);
  localparam logic [7:0] LANE0_KEEP = 8'hFF << ALIGN;

  logic [NB-1:0]    span;
  logic [NB-1:0]    lane_en;
  logic [PTR_W-1:0] wshift;
  logic [PTR_W-1:0] rmask;
  logic [PTR_W-1:0] base_q;

  always_comb begin
    case (size_i)
      2'd0:    span = NB'(1);
      2'd1:    span = NB'(3);
      default: span = '1;
    endcase
    lane_en = span << off_i;
    wshift  = wdata_i << {off_i, 3'b000};
  end

  for (genvar g = 0; g < NB; g++) begin : g_lane
    logic [7:0] lane_d;
    always_comb begin
      lane_d = wshift[g*8 +: 8];
      if (g == 0) lane_d = lane_d & LANE0_KEEP;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 base_q[g*8 +: 8] <= 8'h00;
      else if (wr_i && lane_en[g]) base_q[g*8 +: 8] <= lane_d;
    end
    assign rmask[g*8 +: 8] = {8{span[g]}};
  end

  assign base_o  = base_q;
  assign rdata_o = (base_q >> {off_i, 3'b000}) & rmask;

  p_align_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> (base_q[ALIGN-1:0] == '0));

  p_lane_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && size_i == 2'd0 && off_i == OFF_W'(NB-1)) |=>
      (base_q[PTR_W-9:0] == $past(base_q[PTR_W-9:0])));

endmodule

// File: rtl/bmr_cmd_ctl.sv
module bmr_cmd_ctl
  import bmr_pkg::*;
#(
  parameter int PTR_W = 32,
  parameter int STEP  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_wr_i,
  input  logic [7:0]       wdata_i,
  input  logic [PTR_W-1:0] base_i,
  input  logic             wk_busy_i,
  input  logic             wk_advance_i,
  input  logic             wk_done_i,
  input  logic             wk_exhaust_i,
  output logic             run_o,
  output logic             dir_o,
  output logic             active_o,
  output logic             start_o,
  output logic             stop_o,
  output logic [PTR_W-1:0] fetch_o
);
  logic             run_q, dir_q, act_q, pend_q, start_q, stop_q;
  logic [PTR_W-1:0] fetch_q;
  logic             start_evt, stop_evt, stop_now, kick;

  always_comb begin
    start_evt = cmd_wr_i &&  wdata_i[CMD_RUN_BIT] && !run_q;
    stop_evt  = cmd_wr_i && !wdata_i[CMD_RUN_BIT] &&  run_q;
    kick      = start_evt && !act_q;
    stop_now  = !wk_busy_i && (stop_evt || (pend_q && !start_evt));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      dir_q   <= 1'b0;
      act_q   <= 1'b0;
      pend_q  <= 1'b0;
      start_q <= 1'b0;
      stop_q  <= 1'b0;
      fetch_q <= '0;
    end else begin
      if (cmd_wr_i) begin
        run_q <= wdata_i[CMD_RUN_BIT];
        dir_q <= wdata_i[CMD_DIR_BIT];
      end
      if (start_evt)     pend_q <= 1'b0;
      else if (stop_evt) pend_q <= wk_busy_i;
      else               pend_q <= pend_q && wk_busy_i;
      start_q <= kick;
      stop_q  <= stop_now;
      if (kick)                                       act_q <= 1'b1;
      else if (stop_now || wk_done_i || wk_exhaust_i) act_q <= 1'b0;
      if (start_evt)         fetch_q <= base_i;
      else if (wk_advance_i) fetch_q <= fetch_q + PTR_W'(STEP);
    end
  end

  assign run_o    = run_q;
  assign dir_o    = dir_q;
  assign active_o = act_q;
  assign start_o  = start_q;
  assign stop_o   = stop_q;
  assign fetch_o  = fetch_q;

  p_cmd_keep_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr_i |=> (run_q == $past(wdata_i[CMD_RUN_BIT])) && (dir_q == $past(wdata_i[CMD_DIR_BIT])));

  p_same_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr_i && wdata_i[CMD_RUN_BIT] == run_q && !pend_q) |=> (!start_q && !stop_q));

  p_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (fetch_q == $past(base_i)));

  p_kick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> (act_q && start_q));

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && wk_busy_i && act_q && !wk_done_i && !wk_exhaust_i && !start_evt) |=> act_q);

  p_no_abort_r4: assert property (@(posedge clk) disable iff (!rst_n)
    stop_q |-> !$past(wk_busy_i));

  p_finish_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((wk_done_i || wk_exhaust_i) && !kick) |=> !act_q);

  p_pulse_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_q && stop_q));

endmodule

// File: rtl/bmr_status.sv
module bmr_status
  import bmr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       st_wr_i,
  input  logic [7:0] wdata_i,
  input  logic       exhaust_i,
  input  logic       drv_irq_i,
  output logic       err_o,
  output logic       int_o,
  output logic       host_irq_o
);
  logic irq_q, err_q, int_q, irq_rise;

  assign irq_rise = drv_irq_i && !irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
      err_q <= 1'b0;
      int_q <= 1'b0;
    end else begin
      irq_q <= drv_irq_i;
      err_q <= (err_q && !(st_wr_i && wdata_i[ST_ERR_BIT])) || exhaust_i;
      int_q <= (int_q && !(st_wr_i && wdata_i[ST_INT_BIT])) || irq_rise;
    end
  end

  assign err_o      = err_q;
  assign int_o      = int_q;
  assign host_irq_o = drv_irq_i;

  p_irq_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rise |=> int_q);

  p_irq_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!drv_irq_i && !st_wr_i) |=> (int_q == $past(int_q)));

  p_err_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    exhaust_i |=> err_q);

  p_w1c_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_wr_i && wdata_i[ST_ERR_BIT] && !exhaust_i) |=> !err_q);

endmodule

// File: rtl/bmr_regs.sv
module bmr_regs
  import bmr_pkg::*;
#(
  parameter int PTR_W = 32,
  parameter int ALIGN = 2,
  parameter int STEP  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_valid,
  input  logic             acc_write,
  input  logic [1:0]       acc_sel,
  input  logic [1:0]       acc_off,
  input  logic [1:0]       acc_size,
  input  logic [PTR_W-1:0] acc_wdata,
  output logic [PTR_W-1:0] acc_rdata,
  output logic             wk_start,
  output logic             wk_stop,
  output logic [PTR_W-1:0] wk_fetch_ptr,
  output logic             wk_dir,
  input  logic             wk_busy,
  input  logic             wk_advance,
  input  logic             wk_done,
  input  logic             wk_exhaust,
  output logic             chan_active,
  input  logic             drv_irq,
  output logic             host_irq
);
  localparam int NB    = PTR_W / 8;
  localparam int OFF_W = (NB > 1) ? $clog2(NB) : 1;

  bmr_sel_e         sel;
  logic             wr_cmd, wr_st, wr_base;
  logic             run, err, intr;
  logic [PTR_W-1:0] base, base_rd;
  logic [7:0]       cmd_byte, st_byte;

  assign sel     = bmr_sel_e'(acc_sel);
  assign wr_cmd  = acc_valid && acc_write && sel == SEL_CMD;
  assign wr_st   = acc_valid && acc_write && sel == SEL_STAT;
  assign wr_base = acc_valid && acc_write && sel == SEL_BASE;

  bmr_base_reg #(.PTR_W(PTR_W), .ALIGN(ALIGN)) u_base (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (wr_base),
    .off_i   (OFF_W'(acc_off)),
    .size_i  (acc_size),
    .wdata_i (acc_wdata),
    .base_o  (base),
    .rdata_o (base_rd)
  );

  bmr_cmd_ctl #(.PTR_W(PTR_W), .STEP(STEP)) u_cmd (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_wr_i     (wr_cmd),
    .wdata_i      (acc_wdata[7:0]),
    .base_i       (base),
    .wk_busy_i    (wk_busy),
    .wk_advance_i (wk_advance),
    .wk_done_i    (wk_done),
    .wk_exhaust_i (wk_exhaust),
    .run_o        (run),
    .dir_o        (wk_dir),
    .active_o     (chan_active),
    .start_o      (wk_start),
    .stop_o       (wk_stop),
    .fetch_o      (wk_fetch_ptr)
  );

  bmr_status u_stat (
    .clk        (clk),
    .rst_n      (rst_n),
    .st_wr_i    (wr_st),
    .wdata_i    (acc_wdata[7:0]),
    .exhaust_i  (wk_exhaust),
    .drv_irq_i  (drv_irq),
    .err_o      (err),
    .int_o      (intr),
    .host_irq_o (host_irq)
  );

  always_comb begin
    cmd_byte = 8'h00;
    cmd_byte[CMD_RUN_BIT] = run;
    cmd_byte[CMD_DIR_BIT] = wk_dir;
    st_byte = 8'h00;
    st_byte[ST_ACT_BIT] = chan_active;
    st_byte[ST_ERR_BIT] = err;
    st_byte[ST_INT_BIT] = intr;
    case (sel)
      SEL_CMD:  acc_rdata = PTR_W'(cmd_byte);
      SEL_STAT: acc_rdata = PTR_W'(st_byte);
      SEL_BASE: acc_rdata = base_rd;
      default:  acc_rdata = '0;
    endcase
  end

endmodule

// File: tb/bmr_regs_test.sv
module bmr_regs_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 0, acc_write = 0;
  logic [1:0]  acc_sel = 0, acc_off = 0, acc_size = 0;
  logic [31:0] acc_wdata = 0, acc_rdata;
  logic        wk_start, wk_stop, wk_dir, chan_active, host_irq;
  logic [31:0] wk_fetch_ptr;
  logic        wk_busy = 0, wk_advance = 0, wk_done = 0, wk_exhaust = 0, drv_irq = 0;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  bmr_regs uut (.*);

  // behavioural reference model
  bit          m_run, m_dir, m_act, m_err, m_int, m_pend, m_sp, m_stp, m_irq;
  logic [31:0] m_base, m_fetch;

  always @(posedge clk) begin
    if (!rst_n) begin
      {m_run, m_dir, m_act, m_err, m_int, m_pend, m_sp, m_stp, m_irq} = '0;
      m_base = 0; m_fetch = 0;
    end else begin
      bit go, halt, stopnow, kick;
      int nb;
      go   = acc_valid && acc_write && acc_sel == 0 && acc_wdata[0] && !m_run;
      halt = acc_valid && acc_write && acc_sel == 0 && !acc_wdata[0] && m_run;
      kick = go && !m_act;
      stopnow = !wk_busy && (halt || (m_pend && !go));
      m_sp = kick; m_stp = stopnow;
      if (go) m_fetch = m_base; else if (wk_advance) m_fetch = m_fetch + 8;
      if (kick) m_act = 1; else if (stopnow || wk_done || wk_exhaust) m_act = 0;
      if (go) m_pend = 0; else if (halt) m_pend = wk_busy; else m_pend = m_pend && wk_busy;
      if (acc_valid && acc_write && acc_sel == 0) begin m_run = acc_wdata[0]; m_dir = acc_wdata[3]; end
      if (acc_valid && acc_write && acc_sel == 1) begin
        if (acc_wdata[1]) m_err = 0;
        if (acc_wdata[2]) m_int = 0;
      end
      if (wk_exhaust) m_err = 1;
      if (drv_irq && !m_irq) m_int = 1;
      m_irq = drv_irq;
      if (acc_valid && acc_write && acc_sel == 2) begin
        nb = (acc_size == 0) ? 1 : (acc_size == 1) ? 2 : 4;
        for (int k = 0; k < nb; k++)
          if (acc_off + k < 4) m_base[(acc_off + k)*8 +: 8] = acc_wdata[k*8 +: 8];
        m_base[1:0] = 2'b00;
      end
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // per-cycle comparison, away from the clock edge
  always @(posedge clk) begin
    #2;
    if (rst_n && !finished) begin
      check("R3 start pulse", 32'(wk_start), 32'(m_sp));
      check("R4 stop pulse", 32'(wk_stop), 32'(m_stp));
      check("R11 fetch ptr", wk_fetch_ptr, m_fetch);
      check("R10 active", 32'(chan_active), 32'(m_act));
      check("R1 dir", 32'(wk_dir), 32'(m_dir));
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] s, logic [1:0] o, logic [1:0] z, logic [31:0] d);
    @(negedge clk);
    acc_valid = 1; acc_write = 1; acc_sel = s; acc_off = o; acc_size = z; acc_wdata = d;
    @(negedge clk);
    acc_valid = 0; acc_write = 0; acc_wdata = 0;
  endtask

  task automatic rd(logic [1:0] s, logic [1:0] o, logic [1:0] z, output logic [31:0] d);
    acc_valid = 1; acc_write = 0; acc_sel = s; acc_off = o; acc_size = z;
    #1 d = acc_rdata;
    acc_valid = 0;
  endtask

  task automatic pulse(ref logic sig);
    @(negedge clk); sig = 1;
    @(negedge clk); sig = 0;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      $display("FAIL R8 watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    idle(2);
    rst_n = 1;
    idle(1);
    rd(0, 0, 2, v); check("R8 cmd after reset", v, 0);
    rd(1, 0, 2, v); check("R8 status after reset", v, 0);
    rd(2, 0, 2, v); check("R8 base after reset", v, 0);
    check("R8 fetch after reset", wk_fetch_ptr, 0);

    // table base lanes
    wr(2, 0, 2, 32'h1234_5677);
    rd(2, 0, 2, v); check("R5 word write aligned", v, 32'h1234_5674);
    wr(2, 1, 0, 32'h0000_00AB);
    rd(2, 0, 2, v); check("R5 byte lane 1", v, 32'h1234_AB74);
    wr(2, 2, 1, 32'h0000_BEEF);
    rd(2, 0, 2, v); check("R5 half lanes 2-3", v, 32'hBEEF_AB74);
    wr(2, 3, 1, 32'h0000_55CC);
    rd(2, 0, 2, v); check("R5 half at offset 3 truncated", v, 32'hCCEF_AB74);
    rd(2, 3, 0, v); check("R6 byte read offset 3", v, 32'h0000_00CC);
    rd(2, 1, 1, v); check("R6 half read offset 1", v, 32'h0000_EFAB);
    rd(3, 0, 2, v); check("R6 unused select", v, 0);

    // start
    wr(0, 0, 0, 32'h0000_00FF);
    check("R3 start pulse after run write", 32'(wk_start), 1);
    check("R3 fetch loaded from base", wk_fetch_ptr, 32'hCCEF_AB74);
    rd(0, 0, 2, v); check("R1 cmd keeps bits 0 and 3", v, 32'h09);
    wr(0, 0, 0, 32'h0000_0001);
    check("R2 same run bit no pulse", 32'(wk_start), 0);
    check("R2 direction updated", 32'(wk_dir), 0);

    // advance
    @(negedge clk); wk_advance = 1;
    idle(3); wk_advance = 0;
    idle(1);
    check("R11 fetch advanced by 3 descriptors", wk_fetch_ptr, 32'hCCEF_AB74 + 24);

    // deferred stop
    wk_busy = 1;
    wr(0, 0, 0, 32'h0);
    check("R4 active held while busy", 32'(chan_active), 1);
    check("R4 no stop while busy", 32'(wk_stop), 0);
    idle(3);
    check("R4 still active", 32'(chan_active), 1);
    wk_busy = 0;
    @(negedge clk);
    check("R4 stop pulse after busy ends", 32'(wk_stop), 1);
    check("R4 active cleared", 32'(chan_active), 0);

    // completion
    wr(0, 0, 0, 32'h1);
    pulse(wk_done);
    check("R10 done clears active", 32'(chan_active), 0);
    rd(1, 0, 2, v); check("R10 done leaves error clear", v, 0);
    wr(0, 0, 0, 32'h0);
    wr(0, 0, 0, 32'h1);
    pulse(wk_exhaust);
    rd(1, 0, 2, v); check("R10 exhaust sets error", v, 32'h02);

    // interrupt
    @(negedge clk); drv_irq = 1;
    #1 check("R7 host irq follows", 32'(host_irq), 1);
    @(negedge clk);
    rd(1, 0, 2, v); check("R7 rise sets int", v, 32'h06);
    drv_irq = 0;
    #1 check("R7 host irq falls", 32'(host_irq), 0);
    idle(1);
    rd(1, 0, 2, v); check("R7 fall keeps status", v, 32'h06);

    // write-1-clear
    wr(1, 0, 0, 32'h02);
    rd(1, 0, 2, v); check("R9 clear error only", v, 32'h04);
    wr(0, 0, 0, 32'h0);
    wr(0, 0, 0, 32'h1);
    wr(1, 0, 0, 32'h07);
    rd(1, 0, 2, v); check("R9 bit0 ignores write", v, 32'h01);

    // exhaust racing a software clear
    @(negedge clk);
    acc_valid = 1; acc_write = 1; acc_sel = 1; acc_wdata = 32'h02; wk_exhaust = 1;
    @(negedge clk);
    acc_valid = 0; acc_write = 0; wk_exhaust = 0;
    rd(1, 0, 2, v); check("R10 set wins over clear", v, 32'h02);

    // reset mid-run
    wr(0, 0, 0, 32'h0);
    wr(0, 0, 0, 32'h9);
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    #1;
    check("R8 active cleared by reset", 32'(chan_active), 0);
    check("R8 fetch cleared by reset", wk_fetch_ptr, 0);
    rd(0, 0, 2, v); check("R8 cmd cleared by reset", v, 0);
    rd(2, 0, 2, v); check("R8 base cleared by reset", v, 0);
    idle(2);

    finished = 1;
    summary();
    $finish;
  end
endmodule